// File: doc/BRIEF.md
# I2C Auto-Mode Transaction Sequencer

This block is the byte-level half of an I2C master. Once a transfer word with its run bit set is written, it runs the whole transfer by itself. It sends START, an optional high-speed master-code byte and the address bytes for 7-bit or 10-bit targets. It then moves a counted number of data bytes in one direction and finishes with STOP. When the stop flag is clear it instead holds the bus, so that the next run opens with a repeated START. Bit timing, FIFOs and the pins belong to a bit-level engine. The sequencer drives that engine through a step handshake: it holds `step_valid` with an operation until the engine pulses `step_done` with the ACK and arbitration results.

The current phase is always visible as a fixed 4-bit state code. A status word reports completion, abort, missing-device, missing-ACK and timeout conditions, plus a master-busy flag. A manual port issues one nine-clock read (eight data clocks and a NACK) or one STOP from an idle or held bus. Software uses these two steps to free a bus whose data line is stuck low.

Top module: `i2c_auto_seq`

## Requirements
- R1: A `xfer_wr` strobe starts a transfer only when `xfer_word[31]` is 1, taking the byte count from `xfer_word[7:0]`, read direction from bit 16 (1 = read) and stop-after-transfer from bit 17. With bit 31 at 0 the strobe is ignored. A count of 0 sends only the address phase.
- R2: `state_code` uses the encoding: idle 0x0, start 0x1, restart 0x2, stop 0x3, master code 0x4, first address byte 0x5, second address byte 0x6, address after repeated start 0x7, repeated start inside a 10-bit read 0x8, read 0x9, write 0xA, NACK seen 0xB, arbitration lost 0xC, waiting for TX data 0xD, bus held 0xE.
- R3: A 7-bit transfer issues START, the write byte {addr[6:0], rd}, the data bytes and STOP. Step ops are START=0, RESTART=1, STOP=2, WRITE=3, READ=4. No step is issued in idle.
- R4: In 10-bit mode the sequencer sends {11110, addr[9:8], 0} and then addr[7:0]. A read then adds RESTART and {11110, addr[9:8], 1}.
- R5: In high-speed mode, right after START, the byte 0x08 + `hs_idx` is sent. Its ACK result is ignored.
- R6: With the stop flag clear, the transfer ends in state 0xE with master busy low and done set. The next run begins with RESTART.
- R7: A NACK on any address byte sets status bit 3, passes through state 0xB and ends with STOP.
- R8: A NACK on a written data byte sets status bit 2 and ends with STOP, without consuming that TX byte.
- R9: Lost arbitration on any step sets status bit 1 and goes through state 0xC to idle with no STOP.
- R10: If the engine does not answer a step within `TMO_LIMIT` cycles, status bit 4 is set and the sequencer returns to idle.
- R11: Status bit 0 (done) is set when an automatic transfer completes and is cleared by a `stat_rd` strobe. A new run clears all status flags.
- R12: Status bit 17 (master busy) is high from an accepted run or manual command until the STOP completes or the bus is held. Bit 16 reads 0.
- R13: From idle or a held bus, a manual command with `man_op`=0 issues one READ step with `step_nack`=1 and pushes no data. With `man_op`=1 it issues one STOP. Neither sets done.
- R14: In a read transfer every byte returned by the engine appears on `rx_byte` with a one-cycle `rx_push`. Only the last byte has `step_nack`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| xfer_wr | input | 1 | Transfer word strobe |
| xfer_word | input | 32 | Count, direction, stop flag, run bit |
| tgt_addr | input | 10 | Target address |
| addr10 | input | 1 | 10-bit address mode |
| hs_mode | input | 1 | Send high-speed master code |
| hs_idx | input | 3 | Master code index |
| man_wr | input | 1 | Manual command strobe |
| man_op | input | 1 | 0 = nine-clock read, 1 = STOP |
| stat_rd | input | 1 | Status read strobe, clears done |
| step_valid | output | 1 | Step request to bit engine |
| step_op | output | 3 | Step operation |
| step_byte | output | 8 | Byte for WRITE steps |
| step_nack | output | 1 | Answer NACK on a READ step |
| step_done | input | 1 | Engine finished the step |
| step_ack | input | 1 | ACK received on a WRITE step |
| step_lost | input | 1 | Arbitration lost during the step |
| step_rdata | input | 8 | Byte received on a READ step |
| tx_byte | input | 8 | Next byte to transmit |
| tx_avail | input | 1 | TX byte available |
| tx_take | output | 1 | TX byte consumed |
| rx_byte | output | 8 | Received byte |
| rx_push | output | 1 | Received byte valid |
| state_code | output | 4 | Current state code |
| status | output | 32 | Status flags |

## Verification
The assertions rely on the engine raising `step_done` only while `step_valid` is high, and on `step_lost` and `step_ack` being meaningful only alongside `step_done`. They also assume `xfer_wr` and `man_wr` are never asserted together. The bench models the engine with a fixed three-cycle answer that is given only to a pending step. It pulses each strobe alone for one cycle, and it keeps `tx_byte` stable until `tx_take` consumes it.

// File: rtl/i2c_seq_pkg.sv
// Shared types for the auto-mode sequencer: exposed state codes and step ops.
// Assumes the numeric values are observed by software and must not change.
package i2c_seq_pkg;
    typedef enum logic [3:0] {
        ST_IDLE    = 4'h0,
        ST_START   = 4'h1,
        ST_RESTART = 4'h2,
        ST_STOP    = 4'h3,
        ST_MID     = 4'h4,
        ST_ADDR0   = 4'h5,
        ST_ADDR1   = 4'h6,
        ST_ADDR2   = 4'h7,
        ST_ADDR_SR = 4'h8,
        ST_READ    = 4'h9,
        ST_WRITE   = 4'hA,
        ST_NO_ACK  = 4'hB,
        ST_LOSE    = 4'hC,
        ST_WAIT    = 4'hD,
        ST_HOLD    = 4'hE
    } seq_state_e;

    typedef enum logic [2:0] {
        OP_START   = 3'd0,
        OP_RESTART = 3'd1,
        OP_STOP    = 3'd2,
        OP_WRITE   = 3'd3,
        OP_READ    = 3'd4
    } step_op_e;

    localparam int RUN_BIT  = 31;
    localparam int RD_BIT   = 16;
    localparam int STOP_BIT = 17;
    localparam int BUSY_BIT = 17;
endpackage

// File: rtl/i2c_seq_addr.sv
// Byte selector: forms the byte for every WRITE step from the current state.
// Assumes tgt_addr and the mode inputs are stable for the whole transfer.
module i2c_seq_addr
    import i2c_seq_pkg::*;
(
    input  seq_state_e  st,
    input  logic [9:0]  tgt_addr,
    input  logic        addr10,
    input  logic        rd,
    input  logic [2:0]  hs_idx,
    input  logic [7:0]  tx_byte,
    output logic [7:0]  wbyte
);
    // Pick the outgoing byte for the address, master-code or data phase
    always_comb begin
        case (st)
            ST_MID:   wbyte = {5'b00001, hs_idx};
            ST_ADDR0: wbyte = addr10 ? {5'b11110, tgt_addr[9:8], 1'b0}
                                     : {tgt_addr[6:0], rd};
            ST_ADDR1: wbyte = tgt_addr[7:0];
            ST_ADDR2: wbyte = {5'b11110, tgt_addr[9:8], 1'b1};
            ST_WRITE: wbyte = tx_byte;
            default:  wbyte = 8'h00;
        endcase
    end
endmodule

// File: rtl/i2c_seq_tmo.sv
// Step watchdog: counts cycles a step waits for the engine, pulses on expiry.
// Assumes waiting drops for at least one cycle between separate steps or on expiry.
module i2c_seq_tmo #(
    parameter int TMO_LIMIT = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic waiting,
    output logic expired
);
    localparam int TW = $clog2(TMO_LIMIT + 1);
    logic [TW-1:0] cnt;

    assign expired = waiting && (cnt == TW'(TMO_LIMIT - 1));

    // Count while a step is outstanding, restart otherwise or on expiry
    always_ff @(posedge clk) begin
        if (!rst_n || !waiting || expired) cnt <= '0;
        else                               cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/i2c_seq_flags.sv
// Sticky status flags: set pulses win over clears; done also clears on read.
// Assumes clr_all comes only when a new transfer is accepted.
module i2c_seq_flags (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr_all,
    input  logic       rd_clr,
    input  logic [4:0] set,
    output logic [4:0] flags
);
    // Hold each flag until its clear condition, giving a new set priority
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags <= '0;
        end else begin
            for (int i = 0; i < 5; i++) begin
                if (set[i])                          flags[i] <= 1'b1;
                else if (clr_all || (i == 0 && rd_clr)) flags[i] <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/i2c_auto_seq.sv
// Auto-mode transaction sequencer: runs a counted I2C transfer step by step
// against an abstract bit engine. Assumes step_done/ack/lost are only valid
// while step_valid is high and that tx_byte stays stable until tx_take.
module i2c_auto_seq
    import i2c_seq_pkg::*;
#(
    parameter int CNT_W     = 8,
    parameter int TMO_LIMIT = 64
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        xfer_wr,
    input  logic [31:0] xfer_word,
    input  logic [9:0]  tgt_addr,
    input  logic        addr10,
    input  logic        hs_mode,
    input  logic [2:0]  hs_idx,
    input  logic        man_wr,
    input  logic        man_op,
    input  logic        stat_rd,
    output logic        step_valid,
    output logic [2:0]  step_op,
    output logic [7:0]  step_byte,
    output logic        step_nack,
    input  logic        step_done,
    input  logic        step_ack,
    input  logic        step_lost,
    input  logic [7:0]  step_rdata,
    input  logic [7:0]  tx_byte,
    input  logic        tx_avail,
    output logic        tx_take,
    output logic [7:0]  rx_byte,
    output logic        rx_push,
    output logic [3:0]  state_code,
    output logic [31:0] status
);
    seq_state_e       st, st_n;
    logic [CNT_W-1:0] cnt, cnt_n;
    logic             rd, rd_n, stp, stp_n, held, held_n, man, man_n, fail, fail_n;
    logic             push_n, take_n, clr_all, tmo_exp, acc, run_req;
    logic [4:0]       set_f, flags;
    seq_state_e       fin_st, data_nx;
    logic             unused_bits;

    assign unused_bits = ^{xfer_word[30:18], xfer_word[15:CNT_W]};
    assign run_req     = xfer_wr && xfer_word[RUN_BIT];
    assign acc         = step_valid && step_done;
    assign fin_st      = stp ? ST_STOP : ST_HOLD;
    assign data_nx     = (cnt == '0) ? fin_st : (rd ? ST_READ : ST_WAIT);

    // Which states hold a step request open, and which op each one issues
    always_comb begin
        step_valid = 1'b1;
        case (st)
            ST_START:                    step_op = OP_START;
            ST_RESTART, ST_ADDR_SR:      step_op = OP_RESTART;
            ST_STOP:                     step_op = OP_STOP;
            ST_MID, ST_ADDR0, ST_ADDR1,
            ST_ADDR2, ST_WRITE:          step_op = OP_WRITE;
            ST_READ:                     step_op = OP_READ;
            default: begin
                step_op    = OP_START;
                step_valid = 1'b0;
            end
        endcase
    end

    assign step_nack = (st == ST_READ) && (man || cnt == CNT_W'(1));

    i2c_seq_addr u_addr (
        .st(st), .tgt_addr(tgt_addr), .addr10(addr10), .rd(rd),
        .hs_idx(hs_idx), .tx_byte(tx_byte), .wbyte(step_byte)
    );

    i2c_seq_tmo #(.TMO_LIMIT(TMO_LIMIT)) u_tmo (
        .clk(clk), .rst_n(rst_n), .waiting(step_valid && !step_done),
        .expired(tmo_exp)
    );

    i2c_seq_flags u_flags (
        .clk(clk), .rst_n(rst_n), .clr_all(clr_all), .rd_clr(stat_rd),
        .set(set_f), .flags(flags)
    );

    // Next-state and event decode for the whole transfer
    always_comb begin
        st_n = st; cnt_n = cnt; rd_n = rd; stp_n = stp; held_n = held;
        man_n = man; fail_n = fail;
        set_f = '0; clr_all = 1'b0; push_n = 1'b0; take_n = 1'b0;
        if (tmo_exp) begin
            set_f[4] = 1'b1; st_n = ST_IDLE; held_n = 1'b0; man_n = 1'b0;
        end else if (acc && step_lost) begin
            set_f[1] = 1'b1; st_n = ST_LOSE; held_n = 1'b0; man_n = 1'b0;
            fail_n = 1'b1;
        end else begin
            case (st)
                ST_IDLE, ST_HOLD: begin
                    if (run_req) begin
                        clr_all = 1'b1; fail_n = 1'b0; man_n = 1'b0;
                        cnt_n = xfer_word[CNT_W-1:0];
                        rd_n  = xfer_word[RD_BIT];
                        stp_n = xfer_word[STOP_BIT];
                        st_n  = (st == ST_HOLD) ? ST_RESTART : ST_START;
                    end else if (man_wr) begin
                        man_n = 1'b1;
                        st_n  = man_op ? ST_STOP : ST_READ;
                    end
                end
                ST_START:   if (acc) st_n = hs_mode ? ST_MID : ST_ADDR0;
                ST_RESTART: if (acc) st_n = ST_ADDR0;
                ST_MID:     if (acc) st_n = ST_ADDR0;
                ST_ADDR_SR: if (acc) st_n = ST_ADDR2;
                ST_ADDR0, ST_ADDR1, ST_ADDR2: begin
                    if (acc && !step_ack) begin
                        set_f[3] = 1'b1; fail_n = 1'b1; st_n = ST_NO_ACK;
                    end else if (acc) begin
                        if (st == ST_ADDR0 && addr10)      st_n = ST_ADDR1;
                        else if (st == ST_ADDR1 && rd)     st_n = ST_ADDR_SR;
                        else                               st_n = data_nx;
                    end
                end
                ST_WAIT: if (tx_avail) st_n = ST_WRITE;
                ST_WRITE: begin
                    if (acc && !step_ack) begin
                        set_f[2] = 1'b1; fail_n = 1'b1; st_n = ST_NO_ACK;
                    end else if (acc) begin
                        take_n = 1'b1; cnt_n = cnt - 1'b1;
                        st_n = (cnt == CNT_W'(1)) ? fin_st : ST_WAIT;
                    end
                end
                ST_READ: begin
                    if (acc && man) begin
                        man_n = 1'b0; st_n = held ? ST_HOLD : ST_IDLE;
                    end else if (acc) begin
                        push_n = 1'b1; cnt_n = cnt - 1'b1;
                        st_n = (cnt == CNT_W'(1)) ? fin_st : ST_READ;
                    end
                end
                ST_STOP: begin
                    if (acc) begin
                        if (!man && !fail) set_f[0] = 1'b1;
                        st_n = ST_IDLE; held_n = 1'b0; man_n = 1'b0;
                    end
                end
                ST_NO_ACK: st_n = ST_STOP;
                ST_LOSE:   st_n = ST_IDLE;
                default:   st_n = ST_IDLE;
            endcase
            if (st_n == ST_HOLD && st != ST_HOLD && !man) set_f[0] = 1'b1;
            if (st_n == ST_HOLD) held_n = 1'b1;
        end
    end

    // State, transfer context and registered data-side pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= ST_IDLE; cnt <= '0; rd <= 1'b0; stp <= 1'b0; held <= 1'b0;
            man <= 1'b0; fail <= 1'b0; rx_push <= 1'b0; rx_byte <= '0;
            tx_take <= 1'b0;
        end else begin
            st <= st_n; cnt <= cnt_n; rd <= rd_n; stp <= stp_n; held <= held_n;
            man <= man_n; fail <= fail_n; rx_push <= push_n; tx_take <= take_n;
            if (push_n) rx_byte <= step_rdata;
        end
    end

    assign state_code = st;

    // Status word: flags in the low bits, master busy above, slave busy zero
    always_comb begin
        status           = '0;
        status[4:0]      = flags;
        status[BUSY_BIT] = (st != ST_IDLE) && (st != ST_HOLD);
    end
endmodule

// File: rtl/i2c_auto_seq_chk.sv
// Protocol checker for i2c_auto_seq, attached by bind below.
// Assumes engine answers only pending steps and strobes are never simultaneous.
module i2c_auto_seq_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        xfer_wr,
    input logic        xfer_run,
    input logic        man_wr,
    input logic        stat_rd,
    input logic        step_valid,
    input logic        step_done,
    input logic        step_ack,
    input logic        step_lost,
    input logic        rx_push,
    input logic [3:0]  state_code,
    input logic [31:0] status
);
    assert_state_legal_R2: assert property (@(posedge clk) disable iff (!rst_n)
        state_code != 4'hF);
    assert_run_starts_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_code == 4'h0 && xfer_wr && xfer_run) |=> state_code == 4'h1);
    assert_idle_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_code == 4'h0) |-> !step_valid);
    assert_held_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_code == 4'hE && xfer_wr && xfer_run) |=> state_code == 4'h2);
    assert_addr_nack_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (step_valid && step_done && !step_ack && !step_lost &&
         (state_code == 4'h5 || state_code == 4'h6 || state_code == 4'h7))
        |=> (state_code == 4'hB && status[3]));
    assert_lost_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (step_valid && step_done && step_lost) |=> (state_code == 4'hC && status[1]));
    assert_done_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && state_code == 4'h0 && !xfer_wr) |=> !status[0]);
    assert_busy_rise_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status[17]) |-> $past(xfer_wr || man_wr));
    assert_rx_from_read_R14: assert property (@(posedge clk) disable iff (!rst_n)
        rx_push |-> $past(state_code) == 4'h9);
endmodule

bind i2c_auto_seq i2c_auto_seq_chk u_chk (
    .clk(clk), .rst_n(rst_n), .xfer_wr(xfer_wr), .xfer_run(xfer_word[31]),
    .man_wr(man_wr), .stat_rd(stat_rd), .step_valid(step_valid),
    .step_done(step_done), .step_ack(step_ack), .step_lost(step_lost),
    .rx_push(rx_push), .state_code(state_code), .status(status)
);

// File: tb/i2c_auto_seq_bench.sv
// Scoreboard bench: tasks queue expected engine steps and RX bytes, an engine
// model answers steps and a monitor compares what the sequencer issues.
module i2c_auto_seq_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        xfer_wr = 1'b0;
    logic [31:0] xfer_word = '0;
    logic [9:0]  tgt_addr = 10'h052;
    logic        addr10 = 1'b0, hs_mode = 1'b0;
    logic [2:0]  hs_idx = 3'd5;
    logic        man_wr = 1'b0, man_op = 1'b0, stat_rd = 1'b0;
    logic        step_valid, step_nack, tx_take, rx_push;
    logic [2:0]  step_op;
    logic [7:0]  step_byte, rx_byte;
    logic        step_done = 1'b0, step_ack = 1'b0, step_lost = 1'b0;
    logic [7:0]  step_rdata = '0;
    logic [7:0]  tx_byte = '0;
    logic        tx_avail = 1'b0;
    logic [3:0]  state_code;
    logic [31:0] status;

    int n_chk = 0, n_fail = 0, cyc = 0;
    int lat = 0, step_no = 0, nack_at = -1, lost_at = -1;
    bit hang = 0, man_mode = 0;
    logic [11:0] exp_q[$];
    logic [7:0]  rx_q[$];
    logic [7:0]  tx_q[$];
    string       cur_req = "R3";

    i2c_auto_seq u_i2c_auto_seq (.*);

    always #5 clk = ~clk;

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic exp_step(input logic [2:0] op, input logic nk, input logic [7:0] b);
        exp_q.push_back({op, nk, b});
    endtask

    task automatic tx_load(input logic [7:0] b);
        tx_q.push_back(b);
        tx_avail = 1'b1;
        tx_byte  = tx_q[0];
    endtask

    task automatic tx_clear();
        tx_q.delete();
        tx_avail = 1'b0;
    endtask

    task automatic wait_end();
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            if (state_code == 4'h0 || state_code == 4'hE) break;
        end
    endtask

    task automatic run(input logic [31:0] w);
        step_no = 0;
        @(negedge clk); xfer_word = w; xfer_wr = 1'b1;
        @(negedge clk); xfer_wr = 1'b0;
    endtask

    task automatic manual(input logic op);
        step_no = 0; man_mode = 1;
        @(negedge clk); man_op = op; man_wr = 1'b1;
        @(negedge clk); man_wr = 1'b0;
        wait_end();
        man_mode = 0;
    endtask

    task automatic queue_empty(input string req);
        check(exp_q.size() == 0 && rx_q.size() == 0, req, exp_q.size(), 0);
        exp_q.delete(); rx_q.delete();
    endtask

    // Engine model and step scoreboard: answers each step after three cycles
    always @(negedge clk) begin
        if (!rst_n) begin
            step_done = 1'b0; lat = 0;
        end else if (step_done) begin
            step_done = 1'b0; lat = 0;
        end else if (step_valid && !hang) begin
            lat++;
            if (lat >= 3) begin
                step_done  = 1'b1;
                step_ack   = (step_no != nack_at);
                step_lost  = (step_no == lost_at);
                step_rdata = 8'hC0 + 8'(step_no);
                if (exp_q.size() == 0) begin
                    check(0, cur_req, {step_op, step_nack, step_byte}, 12'h000);
                end else begin
                    logic [11:0] e;
                    e = exp_q.pop_front();
                    if (e[11:9] == 3'd3)
                        check({step_op, step_nack, step_byte} == e, cur_req,
                              {step_op, step_nack, step_byte}, e);
                    else
                        check({step_op, step_nack} == e[11:8], cur_req,
                              {step_op, step_nack}, e[11:8]);
                end
                if (step_op == 3'd4 && !man_mode && !step_lost)
                    rx_q.push_back(step_rdata);
                step_no++;
            end
        end else begin
            lat = 0;
        end
    end

    // Data-side monitor: pops consumed TX bytes and compares pushed RX bytes
    always @(negedge clk) begin
        if (rst_n && tx_take && tx_q.size() > 0) begin
            void'(tx_q.pop_front());
            tx_avail = (tx_q.size() > 0);
            tx_byte  = tx_avail ? tx_q[0] : 8'h00;
        end
        if (rst_n && rx_push) begin
            if (rx_q.size() == 0) check(0, "R14", rx_byte, 8'h00);
            else begin
                logic [7:0] e;
                e = rx_q.pop_front();
                check(rx_byte == e, "R14", rx_byte, e);
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still prints the summary
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // Reset state: idle code, clear status, no step (R2, R12)
        check(state_code == 4'h0, "R2", state_code, 4'h0);
        check(status == 32'h0, "R12", status, 32'h0);
        check(!step_valid, "R3", step_valid, 0);

        // R1: strobe without run bit is ignored
        cur_req = "R1";
        run(32'h0002_0003);
        repeat (4) @(negedge clk);
        check(state_code == 4'h0 && !step_valid, "R1", state_code, 4'h0);

        // R3: 7-bit write of two bytes with stop
        cur_req = "R3";
        tx_load(8'h11); tx_load(8'h22);
        exp_step(0, 0, 0); exp_step(3, 0, 8'hA4); exp_step(3, 0, 8'h11);
        exp_step(3, 0, 8'h22); exp_step(2, 0, 0);
        run(32'h8002_0002);
        check(status[17] == 1'b1, "R12", status[17], 1);
        wait_end();
        check(status == 32'h1, "R11", status, 32'h1);
        queue_empty("R3");
        @(negedge clk); stat_rd = 1'b1;
        @(negedge clk); stat_rd = 1'b0;
        check(status[0] == 1'b0, "R11", status[0], 0);

        // R14: 7-bit read of three bytes, last one NACKed
        cur_req = "R14";
        exp_step(0, 0, 0); exp_step(3, 0, 8'hA5); exp_step(4, 0, 0);
        exp_step(4, 0, 0); exp_step(4, 1, 0); exp_step(2, 0, 0);
        run(32'h8003_0003);
        wait_end();
        repeat (2) @(negedge clk);
        queue_empty("R14");

        // R6: write without stop holds the bus, next run uses RESTART
        cur_req = "R6";
        tx_load(8'h33);
        exp_step(0, 0, 0); exp_step(3, 0, 8'hA4); exp_step(3, 0, 8'h33);
        run(32'h8000_0001);
        wait_end();
        check(state_code == 4'hE, "R6", state_code, 4'hE);
        check(status == 32'h1, "R6", status, 32'h1);
        exp_step(1, 0, 0); exp_step(3, 0, 8'hA5); exp_step(4, 1, 0); exp_step(2, 0, 0);
        run(32'h8003_0001);
        wait_end();
        repeat (2) @(negedge clk);
        check(state_code == 4'h0 && status == 32'h1, "R6", status, 32'h1);
        queue_empty("R6");

        // R4: 10-bit write then 10-bit read
        cur_req = "R4";
        tgt_addr = 10'h2B5; addr10 = 1'b1;
        tx_load(8'h44);
        exp_step(0, 0, 0); exp_step(3, 0, 8'hF4); exp_step(3, 0, 8'hB5);
        exp_step(3, 0, 8'h44); exp_step(2, 0, 0);
        run(32'h8002_0001);
        wait_end();
        queue_empty("R4");
        exp_step(0, 0, 0); exp_step(3, 0, 8'hF4); exp_step(3, 0, 8'hB5);
        exp_step(1, 0, 0); exp_step(3, 0, 8'hF5); exp_step(4, 1, 0); exp_step(2, 0, 0);
        run(32'h8003_0001);
        wait_end();
        repeat (2) @(negedge clk);
        queue_empty("R4");

        // R5: high-speed master code, its NACK ignored; zero-length transfer (R1)
        cur_req = "R5";
        tgt_addr = 10'h052; addr10 = 1'b0; hs_mode = 1'b1; nack_at = 1;
        exp_step(0, 0, 0); exp_step(3, 0, 8'h0D); exp_step(3, 0, 8'hA4); exp_step(2, 0, 0);
        run(32'h8002_0000);
        wait_end();
        check(status == 32'h1, "R5", status, 32'h1);
        queue_empty("R5");
        hs_mode = 1'b0;

        // R7: address NACK gives no-device and a STOP
        cur_req = "R7";
        tx_load(8'h55);
        exp_step(0, 0, 0); exp_step(3, 0, 8'hA4); exp_step(2, 0, 0);
        run(32'h8002_0001);
        wait_end();
        check(status == 32'h8, "R7", status, 32'h8);
        queue_empty("R7");
        check(tx_q.size() == 1, "R7", tx_q.size(), 1);
        tx_clear();

        // R8: data NACK gives no-ACK, STOP, byte not consumed
        cur_req = "R8";
        nack_at = 2;
        tx_load(8'h66); tx_load(8'h77);
        exp_step(0, 0, 0); exp_step(3, 0, 8'hA4); exp_step(3, 0, 8'h66); exp_step(2, 0, 0);
        run(32'h8002_0002);
        wait_end();
        check(status == 32'h4, "R8", status, 32'h4);
        check(tx_q.size() == 2, "R8", tx_q.size(), 2);
        queue_empty("R8");
        tx_clear(); nack_at = -1;

        // R9: arbitration lost on START, no STOP follows
        cur_req = "R9";
        lost_at = 0;
        tx_load(8'h88);
        exp_step(0, 0, 0);
        run(32'h8002_0001);
        wait_end();
        repeat (6) @(negedge clk);
        check(status == 32'h2 && state_code == 4'h0, "R9", status, 32'h2);
        queue_empty("R9");
        tx_clear(); lost_at = -1;

        // R10: engine never answers, timeout returns to idle
        cur_req = "R10";
        hang = 1;
        run(32'h8002_0001);
        wait_end();
        check(status == 32'h10 && state_code == 4'h0, "R10", status, 32'h10);
        hang = 0; exp_q.delete();

        // R13: manual nine-clock read and manual STOP from idle
        cur_req = "R13";
        exp_step(4, 1, 0);
        manual(1'b0);
        check(state_code == 4'h0 && status[0] == 1'b0, "R13", status, 32'h10);
        queue_empty("R13");
        exp_step(2, 0, 0);
        manual(1'b1);
        check(state_code == 4'h0 && status[0] == 1'b0, "R13", status, 32'h10);
        queue_empty("R13");

        // R13: manual STOP releases a held bus
        tx_load(8'h99);
        exp_step(0, 0, 0); exp_step(3, 0, 8'hA4); exp_step(3, 0, 8'h99);
        run(32'h8000_0001);
        wait_end();
        check(state_code == 4'hE, "R6", state_code, 4'hE);
        exp_step(2, 0, 0);
        manual(1'b1);
        check(state_code == 4'h0 && status[17] == 1'b0, "R13", state_code, 4'h0);
        queue_empty("R13");

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule